// File: doc/BRIEF.md
# Multi-Mode Programmable Timer Channel

This block is a single timer channel built around a 16-bit down-counter. It is clocked by one system clock. The channel's counting clock arrives as a one-cycle enable, `cnt_tick`. A host programs an 8-bit control byte and a 16-bit load value through byte-wide write strobes. It reads the count or the control byte back through a registered read port.

The control byte chooses one of five behaviours, all sharing the one counter:
- a latched timeout level;
- a one-tick strobe;
- a retriggerable gate-started one-shot;
- a self-reloading rate generator;
- a variable duty-cycle waveform whose high and low times are the two bytes of the load value.

The control byte also picks the gate polarity, starts and stops counting, enables a timeout pulse toward a shared interrupt block, and can freeze the value the host reads while counting goes on. The channel drives a true output and its complement.

Top module: `prog_timer_chan`

## Requirements
- R1: After reset, out_true is 0, out_comp is 1, tmo_irq is 0, the count reads 0 and the control byte reads 0.
- R2: Control byte fields are as follows: bits 2:0 are the mode (1 timeout, 2 strobe, 3 one-shot, 4 rate, 5 duty; other values never count), bit 3 is gate polarity (1 = gate_in high is active), bit 4 is run, bit 5 is timeout pulse enable, and bit 6 is read-hold. In modes 1, 2, 4 and 5 the count steps down by one per cnt_tick only while run is 1 and gate_in is at its active level.
- R3: A load byte write while run is 0 presets the counter (and the output state) two clock cycles later. A write while run is 1 changes only the reload value and leaves the count untouched.
- R4: Mode 1 sets out_true to 1 on the tick that brings the count to 0. It stays 1 and the counter stays at 0 until the next preset.
- R5: Mode 2 sets out_true to 1 on the tick that reaches 0 and clears it on the next cnt_tick, a pulse one tick period wide.
- R6: Mode 3 counts only after an inactive-to-active gate transition while run is 1. Each such transition reloads the count from the load value and clears out_true. Reaching 0 sets out_true and stops counting.
- R7: Mode 4 reloads the count from the load value on the tick that reaches 0. It raises out_true for one tick period, so a load of N gives one pulse per N ticks.
- R8: Mode 5 treats load bits 15:8 as the high time and bits 7:0 as the low time in ticks, with a zero byte meaning 256. A preset sets out_true to 1 and loads the high time; each time the count runs out, the output flips and the other time is loaded.
- R9: out_comp is always the inverse of out_true.
- R10: Setting read-hold captures the count at that control write. While it stays set, reads return the captured value as counting continues; clearing it returns reads to the live count.
- R11: tmo_irq is a one-cycle pulse in the cycle after a tick takes the count from 1 to its zero event, and only when bit 5 is set.
- R12: The counter never wraps below 0. A count of 0 is left unchanged except by a preset, a mode 3 trigger or a mode 4 reload, and a load of 0 produces no zero event.
- R13: A read strobe with rd_sel 0 returns count bits 7:0, rd_sel 1 returns bits 15:8, rd_sel 2 returns the control byte and rd_sel 3 returns 0, on rd_data one cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | One-cycle counting-clock enable |
| gate_in | input | 1 | Gate input, polarity set by control bit 3 |
| wr_ctrl | input | 1 | Write wr_data to the control byte |
| wr_load_lo | input | 1 | Write wr_data to load bits 7:0 |
| wr_load_hi | input | 1 | Write wr_data to load bits 15:8 |
| wr_data | input | 8 | Host write data |
| rd_stb | input | 1 | Read strobe |
| rd_sel | input | 2 | Read source select |
| rd_data | output | 8 | Registered read data |
| out_true | output | 1 | Channel output |
| out_comp | output | 1 | Complement of out_true |
| tmo_irq | output | 1 | Timeout pulse toward the interrupt block |

## Verification
The bench builds the channel with its default 16-bit counter and 8-bit host bus, so both count bytes and the control byte are read back through the normal port. Small load values bring every zero crossing, reload and phase flip within a few ticks. A duty load with a zero high byte reaches the 256-tick limit and the turn of the phase that follows it. Gate polarity, retriggers, read-hold and loads written while running are driven directly, and each is observed through the read port and the outputs.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    localparam int BUS_W  = 8;
    localparam int CNT_W  = 2 * BUS_W;
    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] MODE_TIMEOUT = 3'd1;
    localparam logic [MODE_W-1:0] MODE_STROBE  = 3'd2;
    localparam logic [MODE_W-1:0] MODE_ONESHOT = 3'd3;
    localparam logic [MODE_W-1:0] MODE_RATE    = 3'd4;
    localparam logic [MODE_W-1:0] MODE_DUTY    = 3'd5;

    // control byte layout, msb first
    typedef struct packed {
        logic              spare;
        logic              hold;
        logic              irq_en;
        logic              run;
        logic              gate_hi;
        logic [MODE_W-1:0] mode;
    } ctrl_t;

    // one duty phase length in ticks: a zero byte stands for 2**BUS_W
    function automatic logic [CNT_W-1:0] phase_len(input logic [BUS_W-1:0] b);
        logic [CNT_W-1:0] r;
        r = {{(CNT_W-BUS_W){1'b0}}, b};
        if (b == '0) r = CNT_W'(1) << BUS_W;
        return r;
    endfunction
endpackage

// File: rtl/tmr_gate_sense.sv
`timescale 1ns/1ps
module tmr_gate_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_in,
    input  logic gate_hi,
    output logic gate_lvl,
    output logic gate_rise
);
    typedef struct packed {
        logic prev;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     active_now;

    always_comb begin
        active_now = gate_hi ? gate_in : ~gate_in;
        st_d       = st_q;
        st_d.prev  = active_now;
        gate_lvl   = active_now;
        gate_rise  = active_now & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr_host_port.sv
`timescale 1ns/1ps
module tmr_host_port
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             rd_stb,
    input  logic [1:0]       rd_sel,
    input  logic [CNT_W-1:0] count,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] load,
    output logic             preset,
    output logic [BUS_W-1:0] rd_data
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] snap;
        logic             preset;
        logic [BUS_W-1:0] rd;
    } host_st_t;

    host_st_t         st_d, st_q;
    ctrl_t            new_ctrl;
    logic [CNT_W-1:0] view;

    always_comb begin
        st_d        = st_q;
        new_ctrl    = ctrl_t'(wr_data);
        st_d.preset = (wr_lo | wr_hi) & ~st_q.ctrl.run;

        if (wr_ctrl) begin
            st_d.ctrl = new_ctrl;
            if (new_ctrl.hold && !st_q.ctrl.hold) st_d.snap = count;
        end
        if (wr_lo) st_d.load[BUS_W-1:0]     = wr_data;
        if (wr_hi) st_d.load[CNT_W-1:BUS_W] = wr_data;

        view = st_q.ctrl.hold ? st_q.snap : count;
        if (rd_stb) begin
            unique case (rd_sel)
                2'd0:    st_d.rd = view[BUS_W-1:0];
                2'd1:    st_d.rd = view[CNT_W-1:BUS_W];
                2'd2:    st_d.rd = st_q.ctrl;
                default: st_d.rd = '0;
            endcase
        end

        ctrl    = st_q.ctrl;
        load    = st_q.load;
        preset  = st_q.preset;
        rd_data = st_q.rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr_count_core.sv
`timescale 1ns/1ps
module tmr_count_core
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              gate_lvl,
    input  logic              gate_rise,
    input  logic [MODE_W-1:0] mode,
    input  logic              run,
    input  logic              irq_en,
    input  logic [CNT_W-1:0]  load,
    input  logic              preset,
    output logic [CNT_W-1:0]  count,
    output logic              out,
    output logic              irq,
    output logic              trig
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             out;
        logic             armed;
        logic             irq;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     level_mode;
    logic     step;
    logic     pulse_mode;

    always_comb begin
        level_mode = (mode == MODE_TIMEOUT) || (mode == MODE_STROBE) ||
                     (mode == MODE_RATE)    || (mode == MODE_DUTY);
        pulse_mode = (mode == MODE_STROBE) || (mode == MODE_RATE);
        trig       = run && (mode == MODE_ONESHOT) && gate_rise;
        step       = tick && run &&
                     ((mode == MODE_ONESHOT) ? st_q.armed : (level_mode && gate_lvl));

        st_d     = st_q;
        st_d.irq = 1'b0;

        if (preset) begin
            st_d.armed = 1'b0;
            if (mode == MODE_DUTY) begin
                st_d.cnt = phase_len(load[CNT_W-1:BUS_W]);
                st_d.out = 1'b1;
            end else begin
                st_d.cnt = load;
                st_d.out = 1'b0;
            end
        end else if (trig) begin
            st_d.cnt   = load;
            st_d.armed = 1'b1;
            st_d.out   = 1'b0;
        end else begin
            // a strobe or rate pulse lasts until the following tick
            if (tick && pulse_mode && st_q.out) st_d.out = 1'b0;

            if (step && st_q.cnt != '0) begin
                if (st_q.cnt == CNT_W'(1)) begin
                    st_d.irq = irq_en;
                    unique case (mode)
                        MODE_RATE: begin
                            st_d.cnt = load;
                            st_d.out = 1'b1;
                        end
                        MODE_DUTY: begin
                            st_d.out = ~st_q.out;
                            st_d.cnt = st_q.out ? phase_len(load[BUS_W-1:0])
                                                : phase_len(load[CNT_W-1:BUS_W]);
                        end
                        MODE_ONESHOT: begin
                            st_d.cnt   = '0;
                            st_d.out   = 1'b1;
                            st_d.armed = 1'b0;
                        end
                        default: begin
                            st_d.cnt = '0;
                            st_d.out = 1'b1;
                        end
                    endcase
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
        end

        count = st_q.cnt;
        out   = st_q.out;
        irq   = st_q.irq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/prog_timer_chan.sv
`timescale 1ns/1ps
module prog_timer_chan
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_tick,
    input  logic             gate_in,
    input  logic             wr_ctrl,
    input  logic             wr_load_lo,
    input  logic             wr_load_hi,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             rd_stb,
    input  logic [1:0]       rd_sel,
    output logic [BUS_W-1:0] rd_data,
    output logic             out_true,
    output logic             out_comp,
    output logic             tmo_irq
);
    ctrl_t            ctrl_w;
    logic [CNT_W-1:0] load_w;
    logic [CNT_W-1:0] cnt_w;
    logic             preset_w;
    logic             trig_w;
    logic             gate_lvl_w;
    logic             gate_rise_w;
    logic             out_w;

    tmr_gate_sense u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_in   (gate_in),
        .gate_hi   (ctrl_w.gate_hi),
        .gate_lvl  (gate_lvl_w),
        .gate_rise (gate_rise_w)
    );

    tmr_host_port u_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wr_lo   (wr_load_lo),
        .wr_hi   (wr_load_hi),
        .wr_data (wr_data),
        .rd_stb  (rd_stb),
        .rd_sel  (rd_sel),
        .count   (cnt_w),
        .ctrl    (ctrl_w),
        .load    (load_w),
        .preset  (preset_w),
        .rd_data (rd_data)
    );

    tmr_count_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (cnt_tick),
        .gate_lvl  (gate_lvl_w),
        .gate_rise (gate_rise_w),
        .mode      (ctrl_w.mode),
        .run       (ctrl_w.run),
        .irq_en    (ctrl_w.irq_en),
        .load      (load_w),
        .preset    (preset_w),
        .count     (cnt_w),
        .out       (out_w),
        .irq       (tmo_irq),
        .trig      (trig_w)
    );

    assign out_true = out_w;
    assign out_comp = ~out_w;
endmodule

// File: rtl/tmr_chan_chk.sv
`timescale 1ns/1ps
module tmr_chan_chk
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_tick,
    input logic              out_true,
    input logic              irq,
    input logic [CNT_W-1:0]  count,
    input logic [MODE_W-1:0] mode,
    input logic              preset,
    input logic              trig
);
    // R1: reset leaves the output low and the counter empty
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!out_true && count == '0 && !irq));

    // R2: without a tick, preset or trigger the count does not move
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_tick && !preset && !trig) |=> $stable(count));

    // R4: the timeout level is only cleared by a preset
    a_r4_level_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TIMEOUT && out_true && !preset) |=> out_true);

    // R11: the timeout pulse follows a tick taken at a count of one
    a_r11_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(count) == CNT_W'(1) && $past(cnt_tick)));

    // R12: an empty counter stays empty unless reloaded
    a_r12_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !preset && !trig) |=> count == '0);
endmodule

bind prog_timer_chan tmr_chan_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_tick (cnt_tick),
    .out_true (out_true),
    .irq      (tmo_irq),
    .count    (cnt_w),
    .mode     (ctrl_w.mode),
    .preset   (preset_w),
    .trig     (trig_w)
);

// File: tb/prog_timer_chan_tb.sv
`timescale 1ns/1ps
module prog_timer_chan_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_tick = 1'b0;
    logic       gate_in = 1'b0;
    logic       wr_ctrl = 1'b0;
    logic       wr_load_lo = 1'b0;
    logic       wr_load_hi = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_stb = 1'b0;
    logic [1:0] rd_sel = '0;
    logic [7:0] rd_data;
    logic       out_true;
    logic       out_comp;
    logic       tmo_irq;

    int checks = 0;
    int failures = 0;
    int irq_seen = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    prog_timer_chan u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_tick   (cnt_tick),
        .gate_in    (gate_in),
        .wr_ctrl    (wr_ctrl),
        .wr_load_lo (wr_load_lo),
        .wr_load_hi (wr_load_hi),
        .wr_data    (wr_data),
        .rd_stb     (rd_stb),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data),
        .out_true   (out_true),
        .out_comp   (out_comp),
        .tmo_irq    (tmo_irq)
    );

    always @(negedge clk) if (tmo_irq) irq_seen++;

    typedef struct packed {
        logic [2:0]  mode;
        logic        pol;
        logic        gate;
        logic [15:0] load;
        logic [10:0] ticks;
        logic [15:0] exp_cnt;
        logic        exp_out;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VEC [NVEC] = '{
        '{3'd1, 1'b1, 1'b1, 16'd5,      11'd3,   16'd2,   1'b0}, // R4 counting
        '{3'd1, 1'b1, 1'b1, 16'd5,      11'd5,   16'd0,   1'b1}, // R4 reaches zero
        '{3'd1, 1'b1, 1'b1, 16'd5,      11'd8,   16'd0,   1'b1}, // R4 held
        '{3'd2, 1'b1, 1'b1, 16'd4,      11'd4,   16'd0,   1'b1}, // R5 strobe high
        '{3'd2, 1'b1, 1'b1, 16'd4,      11'd5,   16'd0,   1'b0}, // R5 strobe ends
        '{3'd4, 1'b1, 1'b1, 16'd3,      11'd3,   16'd3,   1'b1}, // R7 reload
        '{3'd4, 1'b1, 1'b1, 16'd3,      11'd4,   16'd2,   1'b0}, // R7 pulse ends
        '{3'd4, 1'b1, 1'b1, 16'd3,      11'd6,   16'd3,   1'b1}, // R7 second period
        '{3'd5, 1'b1, 1'b1, 16'h0203,   11'd1,   16'd1,   1'b1}, // R8 high phase
        '{3'd5, 1'b1, 1'b1, 16'h0203,   11'd2,   16'd3,   1'b0}, // R8 low phase
        '{3'd5, 1'b1, 1'b1, 16'h0203,   11'd5,   16'd2,   1'b1}, // R8 back high
        '{3'd5, 1'b1, 1'b1, 16'h0001,   11'd256, 16'd1,   1'b0}, // R8 zero byte = 256
        '{3'd5, 1'b1, 1'b1, 16'h0001,   11'd257, 16'd256, 1'b1}, // R8 wrap to high
        '{3'd1, 1'b1, 1'b0, 16'd5,      11'd4,   16'd5,   1'b0}, // R2 gate inactive
        '{3'd1, 1'b0, 1'b0, 16'd5,      11'd2,   16'd3,   1'b0}  // R2 active-low gate
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        @(negedge clk); wr_ctrl = 1'b1; wr_data = v;
        @(negedge clk); wr_ctrl = 1'b0;
    endtask

    task automatic write_load(input logic [15:0] v);
        @(negedge clk); wr_load_lo = 1'b1; wr_data = v[7:0];
        @(negedge clk); wr_load_lo = 1'b0; wr_load_hi = 1'b1; wr_data = v[15:8];
        @(negedge clk); wr_load_hi = 1'b0;
        idle(2);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cnt_tick = 1'b1;
            @(negedge clk); cnt_tick = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic read_byte(input logic [1:0] sel, output logic [7:0] v);
        @(negedge clk); rd_stb = 1'b1; rd_sel = sel;
        @(negedge clk); rd_stb = 1'b0; v = rd_data;
    endtask

    task automatic read_count(output int v);
        logic [7:0] lo, hi;
        read_byte(2'd0, lo);
        read_byte(2'd1, hi);
        v = {hi, lo};
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int c;
        logic [7:0] b;
        logic [7:0] cv;

        idle(3);
        // R1 reset state, sampled while reset is held and after release
        chk("R1 out_true", out_true, 0);
        chk("R1 out_comp", out_comp, 1);
        rst_n = 1'b1;
        idle(2);
        chk("R1 tmo_irq", tmo_irq, 0);
        read_count(c);
        chk("R1 count", c, 0);
        read_byte(2'd2, b);
        chk("R1 ctrl", b, 0);
        read_byte(2'd3, b);
        chk("R13 sel3 zero", b, 0);

        // table walk: R2 R4 R5 R7 R8 R9
        for (int k = 0; k < NVEC; k++) begin
            cv = {3'b000, 1'b0, VEC[k].pol, VEC[k].mode};
            write_ctrl(cv);
            gate_in = VEC[k].gate;
            write_load(VEC[k].load);
            write_ctrl(cv | 8'h10);
            tick(int'(VEC[k].ticks));
            read_count(c);
            chk($sformatf("R2/R4/R5/R7/R8 vec%0d count", k), c, int'(VEC[k].exp_cnt));
            chk($sformatf("R4/R5/R7/R8 vec%0d out", k), out_true, int'(VEC[k].exp_out));
            chk($sformatf("R9 vec%0d comp", k), out_comp, int'(!VEC[k].exp_out));
            write_ctrl(cv);
        end

        // R6 gated one-shot with retrigger
        write_ctrl(8'h0B);
        gate_in = 1'b0;
        write_load(16'd4);
        write_ctrl(8'h1B);
        tick(3);
        read_count(c);
        chk("R6 idle before trigger", c, 4);
        @(negedge clk); gate_in = 1'b1;
        idle(2);
        tick(2);
        read_count(c);
        chk("R6 counts after trigger", c, 2);
        @(negedge clk); gate_in = 1'b0;
        idle(1);
        @(negedge clk); gate_in = 1'b1;
        idle(2);
        read_count(c);
        chk("R6 retrigger reloads", c, 4);
        tick(3);
        chk("R6 out before zero", out_true, 0);
        tick(1);
        chk("R6 out at zero", out_true, 1);
        tick(2);
        read_count(c);
        chk("R6 stops at zero", c, 0);
        @(negedge clk); gate_in = 1'b0;
        idle(1);
        @(negedge clk); gate_in = 1'b1;
        idle(2);
        chk("R6 retrigger clears out", out_true, 0);
        read_count(c);
        chk("R6 retrigger after zero", c, 4);

        // R11 timeout pulse with enable set
        write_ctrl(8'h29);
        gate_in = 1'b1;
        write_load(16'd2);
        irq_seen = 0;
        write_ctrl(8'h39);
        tick(1);
        chk("R11 no pulse before zero", irq_seen, 0);
        tick(1);
        chk("R11 one pulse at zero", irq_seen, 1);
        tick(2);
        chk("R11 no pulse after zero", irq_seen, 1);
        // R11 with enable clear
        write_ctrl(8'h09);
        write_load(16'd2);
        write_ctrl(8'h19);
        tick(3);
        chk("R11 pulse disabled", irq_seen, 1);

        // R10 read-hold
        write_ctrl(8'h09);
        write_load(16'd100);
        write_ctrl(8'h19);
        tick(10);
        read_count(c);
        chk("R10 live count", c, 90);
        write_ctrl(8'h59);
        tick(5);
        read_count(c);
        chk("R10 held snapshot", c, 90);
        write_ctrl(8'h19);
        read_count(c);
        chk("R10 live after release", c, 85);
        read_byte(2'd2, b);
        chk("R13 ctrl readback", b, 8'h19);

        // R3 load written while running leaves count
        write_load(16'd7);
        read_count(c);
        chk("R3 running write no preset", c, 85);
        // R2 stopped channel ignores ticks
        write_ctrl(8'h09);
        tick(3);
        read_count(c);
        chk("R2 stopped no count", c, 85);
        write_load(16'd7);
        read_count(c);
        chk("R3 stopped write presets", c, 7);

        // R12 load of zero
        write_load(16'd0);
        write_ctrl(8'h39);
        irq_seen = 0;
        tick(3);
        read_count(c);
        chk("R12 zero load stays zero", c, 0);
        chk("R12 zero load no output", out_true, 0);
        chk("R12 zero load no pulse", irq_seen, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule